// File: doc/BRIEF.md
# Scanning Matrix Keypad Encoder

This block scans a 4x4 key matrix and turns one pressed key into a 4-bit binary code with a valid flag. The rows are driven by an active-low ring counter, which pulls exactly one row low per clock. The columns are sensed through pull-ups, so a pressed key shows up as a low on its column while its row is the one being driven.

When any column reads low, the ring counter stops on the current row. The row position and the lowest low column are each encoded into a 2-bit index. The two indices are joined into the key code and registered. The code leaves the block on a tristate-style bus. It is driven only while a key is held and the external bus enable is high. At all other times it is high impedance. When the key is released, scanning continues from the next row.

Top module: `keymatrix_scan_enc`

## Requirements
- R1: Synchronous active-high reset loads the row drive with 4'b1110 (row 0 low), clears the valid flag, and leaves the code bus at high impedance.
- R2: Exactly one row drive bit is low at any time. While every column reads high, the low bit moves one place per clock toward the higher index: row 0, 1, 2, 3, then back to row 0.
- R3: A pressed key at row r, column c pulls column c low while row r is driven low. A low on any column holds the row drive unchanged for as long as that column stays low.
- R4: The valid flag rises on the clock edge that sees a low column and stays high while the key is held. It does not depend on the bus enable.
- R5: The key code is {row index, column index}, each index 2 bits wide, so its value is 4*r + c. The row index is the bit position of the low row drive and the column index is the bit position of the low column.
- R6: When more than one column is low in the driven row, the code reports the lowest-numbered low column.
- R7: The code bus is high impedance whenever the valid flag is low or the bus enable is low. The bus enable changes the bus within the same cycle.
- R8: One clock after all columns return high, the valid flag is low, the bus is high impedance, and the next row (r+1 mod 4) is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_oe | input | 1 | Enable for the code bus drivers |
| col_sense_n | input | 4 | Column sense lines, active low, pulled up outside the block |
| row_drv_n | output | 4 | Row drive lines, active low, one low at a time |
| key_code | output | 4 | Tristate key code {row, col} |
| key_valid | output | 1 | A key is held and its code is registered |

## Verification
The hardest situation to reach is a press in a row that is not currently being driven. In that case the block must keep rotating and must lock only when the scan reaches that row, so the lock point depends on the ring phase at the moment of the press. The bench models the key matrix as a pressed-key mask and derives the column lines from the row drive in every cycle. It then sweeps all sixteen keys with the bus enable both high and low, and waits for the scan to arrive. This covers every ring phase and every (row, column) pair. Multi-key presses within one row cover the column priority.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  localparam int unsigned KS_ROWS = 4;
  localparam int unsigned KS_COLS = 4;
endpackage

// File: rtl/keyscan_lowenc.sv
module keyscan_lowenc #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  lines_n,
  output logic [IW-1:0] idx,
  output logic          any_low
);
  always_comb begin
    idx     = '0;
    any_low = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!lines_n[i]) begin
        idx     = IW'(i);
        any_low = 1'b1;
      end
    end
  end
endmodule

// File: rtl/keyscan_ring.sv
module keyscan_ring #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  output logic [N-1:0] ring_n
);
  localparam logic [N-1:0] START = ~{{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       ring_n <= START;
    else if (!hold) ring_n <= {ring_n[N-2:0], ring_n[N-1]};
  end

  a_r2_one_row_low: assert property (@(posedge clk) disable iff (rst)
    $countones(~ring_n) == 1);
  a_r3_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(ring_n));
  a_r2_moves_when_idle: assert property (@(posedge clk) disable iff (rst)
    !hold |=> ring_n != $past(ring_n));
endmodule

// File: rtl/keymatrix_scan_enc.sv
module keymatrix_scan_enc
  import keyscan_pkg::*;
#(
  parameter int unsigned ROWS = KS_ROWS,
  parameter int unsigned COLS = KS_COLS,
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned CW = $clog2(COLS),
  localparam int unsigned CODE_W = RW + CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_oe,
  input  logic [COLS-1:0]   col_sense_n,
  output logic [ROWS-1:0]   row_drv_n,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid
);
  logic [RW-1:0]     row_idx;
  logic [CW-1:0]     col_idx;
  logic              col_low;
  logic              row_any;
  logic              hit_q;
  logic [CODE_W-1:0] code_q;

  keyscan_ring #(.N(ROWS)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .hold   (col_low),
    .ring_n (row_drv_n)
  );

  keyscan_lowenc #(.N(ROWS)) u_row_enc (
    .lines_n (row_drv_n),
    .idx     (row_idx),
    .any_low (row_any)
  );

  keyscan_lowenc #(.N(COLS)) u_col_enc (
    .lines_n (col_sense_n),
    .idx     (col_idx),
    .any_low (col_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      code_q <= '0;
    end else begin
      hit_q <= col_low;
      if (col_low) code_q <= {row_idx, col_idx};
    end
  end

  assign key_valid = hit_q;
  assign key_code  = (hit_q && bus_oe) ? code_q : {CODE_W{1'bz}};

  a_r4_valid_needs_low_col: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(col_low));
  a_r4_low_col_gives_valid: assert property (@(posedge clk) disable iff (rst)
    col_low |=> hit_q);
  a_r2_row_driven: assert property (@(posedge clk) disable iff (rst)
    row_any);
  a_r8_release_drops_valid: assert property (@(posedge clk) disable iff (rst)
    (hit_q && !col_low) |=> !hit_q);
endmodule

// File: tb/keymatrix_scan_enc_tb.sv
module keymatrix_scan_enc_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_oe = 1'b1;
  logic [3:0] col_sense_n;
  logic [3:0] row_drv_n;
  wire  [3:0] key_code;
  logic       key_valid;
  logic [15:0] pressed = '0;
  int n_chk = 0;
  int n_bad = 0;

  pullup (key_code[0]);
  pullup (key_code[1]);
  pullup (key_code[2]);
  pullup (key_code[3]);

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      col_sense_n[c] = 1'b1;
      for (int r = 0; r < 4; r++)
        if (pressed[r*4+c] && !row_drv_n[r]) col_sense_n[c] = 1'b0;
    end
  end

  keymatrix_scan_enc u_dut (
    .clk         (clk),
    .rst         (rst),
    .bus_oe      (bus_oe),
    .col_sense_n (col_sense_n),
    .row_drv_n   (row_drv_n),
    .key_code    (key_code),
    .key_valid   (key_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] row_pat(input int r);
    return ~(4'b0001 << r);
  endfunction

  task automatic press_and_check(input int k, input bit oe);
    int r = k / 4;
    int c = k % 4;
    int waited = 0;
    @(negedge clk);
    bus_oe  = oe;
    pressed = 16'b1 << k;
    while (!key_valid && waited < 8) begin
      @(negedge clk);
      waited++;
    end
    chk(key_valid == 1'b1 && waited <= 4, "R4 valid after scan reaches row", waited, 4);
    if (oe) chk(key_code == 4'(k), "R5 code = 4*row+col", key_code, k);
    else    chk(key_code == 4'hF, "R7 bus released with oe low", key_code, 15);
    for (int i = 0; i < 3; i++) begin
      chk(row_drv_n == row_pat(r), "R3 row held while pressed", row_drv_n, row_pat(r));
      @(negedge clk);
    end
    chk(key_valid == 1'b1, "R4 valid stays while held", key_valid, 1);
    pressed = '0;
    @(negedge clk);
    chk(key_valid == 1'b0, "R8 valid drops after release", key_valid, 0);
    chk(key_code == 4'hF, "R8 bus released after release", key_code, 15);
    chk(row_drv_n == row_pat((r + 1) % 4), "R8 scan resumes at next row",
        row_drv_n, row_pat((r + 1) % 4));
    if (c < 0) $display("unused");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(row_drv_n == 4'b1110, "R1 reset row drive", row_drv_n, 14);
    chk(key_valid == 1'b0, "R1 reset valid", key_valid, 0);
    chk(key_code == 4'hF, "R1 reset bus released", key_code, 15);
    rst = 1'b0;
    for (int n = 1; n <= 9; n++) begin
      @(negedge clk);
      chk(row_drv_n == row_pat(n % 4), "R2 rotation order", row_drv_n, row_pat(n % 4));
      chk(key_code == 4'hF, "R7 idle bus released", key_code, 15);
    end
    for (int k = 0; k < 16; k++) begin
      press_and_check(k, 1'b1);
      press_and_check(k, 1'b0);
    end
    // R6: several columns low in one row, lowest wins
    @(negedge clk);
    bus_oe  = 1'b1;
    pressed = (16'b1 << 9) | (16'b1 << 11);
    repeat (6) @(negedge clk);
    chk(key_code == 4'd9, "R6 lowest column wins row 2", key_code, 9);
    pressed = '0;
    @(negedge clk);
    pressed = (16'b1 << 4) | (16'b1 << 6) | (16'b1 << 7);
    repeat (6) @(negedge clk);
    chk(key_code == 4'd4, "R6 lowest column wins row 1", key_code, 4);
    // R7: oe toggled while held, same cycle effect, valid unaffected
    bus_oe = 1'b0;
    #1;
    chk(key_code == 4'hF, "R7 oe low releases bus", key_code, 15);
    chk(key_valid == 1'b1, "R7 oe does not clear valid", key_valid, 1);
    bus_oe = 1'b1;
    #1;
    chk(key_code == 4'd4, "R7 oe high drives code", key_code, 4);
    pressed = '0;
    @(negedge clk);
    chk(key_valid == 1'b0, "R8 multi-key release", key_valid, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule